// File: doc/BRIEF.md
# FPU status and control state unit

This block keeps the control and status bits of a floating-point unit that software normally cannot see. There are five of them: a two-bit rounding mode, an error flag, a boolean flag that holds the last comparison outcome, a result sign flag and an operand length flag. The sequencer issues one command per cycle on a valid/opcode bus. Compare outcomes and operand signs come from the datapath as single-bit inputs. The arithmetic itself happens elsewhere.

All the live state is packed into a 32-bit diagnostic status word at fixed bit positions. A one-bit test result reports the outcome of the test-error and compare commands. A single shadow slot can capture the whole state and later put it back, so that an interrupt handler can change modes freely and then return the interrupted code to exactly where it was.

Top module: `fpu_ctlstat`

## Requirements
- R1: After reset the status word is 32'h0000_0080 and the test bit is 0. This means round-to-nearest, with the error, boolean, sign and length flags all 0 (length 0 is double precision).
- R2: Opcode 1 with `cmd_valid` writes `cmd_rm` into status bits 8:7. The encodings are 0 toward zero, 1 nearest, 2 toward plus infinity and 3 toward minus infinity.
- R3: Opcode 2 sets the error flag, which is status bit 3. Opcode 3 drives the test bit one cycle later with the inverse of the error flag as it stood before the command, and clears the flag. So right after a set, the first test returns 0 and the second returns 1.
- R4: Opcode 4 loads the boolean flag (status bit 4) from `cmp_gt`, and opcode 5 loads it from `cmp_eq`. One cycle after either command, the test bit equals the new boolean value.
- R5: Opcode 6 sets the sign flag (status bit 31) and opcode 7 clears it. Opcode 8 sets it to `sign_a` XOR `sign_b`.
- R6: Opcode 9 (double to single) sets the length flag (status bit 19) to 1. Opcode 10 (single to double) clears it to 0.
- R7: Opcode 11 copies all five state fields into the shadow slot and leaves the live state unchanged. Opcode 12 loads all five fields back from the slot, even after the live state has been overwritten.
- R8: Opcode 13 clears the error flag and selects round-to-nearest. The sign, length and boolean flags are left unchanged.
- R9: After reset the shadow slot holds the reset state, so opcode 12 with no earlier save gives status 32'h0000_0080.
- R10: No state changes while `cmd_valid` is low. Opcodes 0, 14 and 15 change nothing either.
- R11: The test bit changes only one cycle after opcodes 3, 4 and 5. It holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 4 | Command opcode |
| cmd_rm | input | 2 | Rounding mode operand for opcode 1 |
| cmp_gt | input | 1 | Datapath outcome: A greater than B |
| cmp_eq | input | 1 | Datapath outcome: A equal to B |
| sign_a | input | 1 | Sign of first multiply operand |
| sign_b | input | 1 | Sign of second multiply operand |
| status_word | output | 32 | Packed diagnostic state |
| test_bit | output | 1 | Registered result of test-error and compare commands |

## Verification
The bench issues two error tests in a row after a set, so a flag that is not cleared, or is returned without inversion, shows up on the first or second read. It overwrites every field after a save and then restores, so a slot that misses any one field leaves a wrong bit in the word. It restores straight out of reset, which catches a shadow that powers up at zero and would bring back round-toward-zero. Commands with valid low, undefined opcodes and non-test commands are checked against an unchanged word and test bit, which exposes decoding that ignores the strobe or leaks into the result register.

// File: rtl/fpu_ctlstat_pkg.sv
package fpu_ctlstat_pkg;

  localparam int OP_W     = 4;
  localparam int RM_W     = 2;
  localparam int STATUS_W = 32;
  localparam int SIGN_BIT = 31;
  localparam int LEN_BIT  = 19;
  localparam int RM_LSB   = 7;
  localparam int BOOL_BIT = 4;
  localparam int ERR_BIT  = 3;

  localparam logic [RM_W-1:0] RM_ZERO    = 2'd0;
  localparam logic [RM_W-1:0] RM_NEAREST = 2'd1;
  localparam logic [RM_W-1:0] RM_PLUS    = 2'd2;
  localparam logic [RM_W-1:0] RM_MINUS   = 2'd3;

  typedef enum logic [OP_W-1:0] {
    OP_NOP      = 4'd0,
    OP_SET_RM   = 4'd1,
    OP_SET_ERR  = 4'd2,
    OP_TEST_ERR = 4'd3,
    OP_CMP_GT   = 4'd4,
    OP_CMP_EQ   = 4'd5,
    OP_SET_SIGN = 4'd6,
    OP_ABS      = 4'd7,
    OP_MUL_SIGN = 4'd8,
    OP_TO_SGL   = 4'd9,
    OP_TO_DBL   = 4'd10,
    OP_SAVE     = 4'd11,
    OP_RESTORE  = 4'd12,
    OP_INIT     = 4'd13
  } ctl_op_e;

  typedef struct packed {
    logic            sign;
    logic            len;
    logic            boolf;
    logic            err;
    logic [RM_W-1:0] rm;
  } ctl_state_t;

  typedef struct packed {
    logic set_rm;
    logic set_err;
    logic test_err;
    logic cmp_gt;
    logic cmp_eq;
    logic set_sign;
    logic clr_sign;
    logic mul_sign;
    logic to_sgl;
    logic to_dbl;
    logic save;
    logic restore;
    logic init;
  } ctl_strobe_t;

  function automatic ctl_state_t reset_state();
    ctl_state_t s;
    s       = '0;
    s.rm    = RM_NEAREST;
    return s;
  endfunction

  function automatic logic [STATUS_W-1:0] pack_status(ctl_state_t s);
    logic [STATUS_W-1:0] w;
    w                      = '0;
    w[SIGN_BIT]            = s.sign;
    w[LEN_BIT]             = s.len;
    w[RM_LSB+RM_W-1:RM_LSB] = s.rm;
    w[BOOL_BIT]            = s.boolf;
    w[ERR_BIT]             = s.err;
    return w;
  endfunction

endpackage

// File: rtl/fpu_ctlstat_decode.sv
module fpu_ctlstat_decode
  import fpu_ctlstat_pkg::*;
(
  input  logic            cmd_valid,
  input  logic [OP_W-1:0] cmd_op,
  output ctl_strobe_t     strb
);

  always_comb begin
    strb = '0;
    if (cmd_valid) begin
      case (cmd_op)
        OP_SET_RM:   strb.set_rm   = 1'b1;
        OP_SET_ERR:  strb.set_err  = 1'b1;
        OP_TEST_ERR: strb.test_err = 1'b1;
        OP_CMP_GT:   strb.cmp_gt   = 1'b1;
        OP_CMP_EQ:   strb.cmp_eq   = 1'b1;
        OP_SET_SIGN: strb.set_sign = 1'b1;
        OP_ABS:      strb.clr_sign = 1'b1;
        OP_MUL_SIGN: strb.mul_sign = 1'b1;
        OP_TO_SGL:   strb.to_sgl   = 1'b1;
        OP_TO_DBL:   strb.to_dbl   = 1'b1;
        OP_SAVE:     strb.save     = 1'b1;
        OP_RESTORE:  strb.restore  = 1'b1;
        OP_INIT:     strb.init     = 1'b1;
        default:     strb          = '0;
      endcase
    end
  end

endmodule

// File: rtl/fpu_ctlstat_shadow.sv
module fpu_ctlstat_shadow
  import fpu_ctlstat_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        save_i,
  input  ctl_state_t  live_i,
  output ctl_state_t  shadow_o
);

  ctl_state_t shadow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      shadow_q <= reset_state();
    else if (save_i) shadow_q <= live_i;
  end

  assign shadow_o = shadow_q;

  // R7
  save_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    save_i |=> (shadow_q == $past(live_i)));

  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !save_i |=> $stable(shadow_q));

endmodule

// File: rtl/fpu_ctlstat_live.sv
module fpu_ctlstat_live
  import fpu_ctlstat_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  ctl_strobe_t     strb,
  input  logic [RM_W-1:0] rm_arg,
  input  logic            cmp_gt,
  input  logic            cmp_eq,
  input  logic            sign_a,
  input  logic            sign_b,
  input  ctl_state_t      shadow_i,
  output ctl_state_t      state_o,
  output logic            result_o
);

  ctl_state_t st_q, st_d;
  logic       res_q, res_d;
  logic       any_cmd;

  assign any_cmd = (strb != '0);

  always_comb begin
    st_d  = st_q;
    res_d = res_q;
    if (strb.restore)  st_d       = shadow_i;
    if (strb.set_rm)   st_d.rm    = rm_arg;
    if (strb.set_err)  st_d.err   = 1'b1;
    if (strb.test_err) begin
      res_d    = ~st_q.err;
      st_d.err = 1'b0;
    end
    if (strb.cmp_gt) begin
      st_d.boolf = cmp_gt;
      res_d      = cmp_gt;
    end
    if (strb.cmp_eq) begin
      st_d.boolf = cmp_eq;
      res_d      = cmp_eq;
    end
    if (strb.set_sign) st_d.sign  = 1'b1;
    if (strb.clr_sign) st_d.sign  = 1'b0;
    if (strb.mul_sign) st_d.sign  = sign_a ^ sign_b;
    if (strb.to_sgl)   st_d.len   = 1'b1;
    if (strb.to_dbl)   st_d.len   = 1'b0;
    if (strb.init) begin
      st_d.err = 1'b0;
      st_d.rm  = RM_NEAREST;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= reset_state();
      res_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      res_q <= res_d;
    end
  end

  assign state_o  = st_q;
  assign result_o = res_q;

  // R3
  test_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.test_err |=> (!st_q.err && (res_q == !$past(st_q.err))));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_cmd |=> ($stable(st_q) && $stable(res_q)));

  // R7
  restore_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.restore |=> (st_q == $past(shadow_i)));

  // R6
  to_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.to_sgl |=> st_q.len);

  // R5
  mul_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.mul_sign |=> (st_q.sign == ($past(sign_a) ^ $past(sign_b))));

  // R8
  init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.init |=> (!st_q.err && st_q.rm == RM_NEAREST && st_q.sign == $past(st_q.sign)));

  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb.test_err || strb.cmp_gt || strb.cmp_eq) |=> $stable(res_q));

endmodule

// File: rtl/fpu_ctlstat.sv
module fpu_ctlstat
  import fpu_ctlstat_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [OP_W-1:0]     cmd_op,
  input  logic [RM_W-1:0]     cmd_rm,
  input  logic                cmp_gt,
  input  logic                cmp_eq,
  input  logic                sign_a,
  input  logic                sign_b,
  output logic [STATUS_W-1:0] status_word,
  output logic                test_bit
);

  ctl_strobe_t strb;
  ctl_state_t  live_state;
  ctl_state_t  shadow_state;

  fpu_ctlstat_decode u_decode (
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .strb      (strb)
  );

  fpu_ctlstat_live u_live (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .rm_arg   (cmd_rm),
    .cmp_gt   (cmp_gt),
    .cmp_eq   (cmp_eq),
    .sign_a   (sign_a),
    .sign_b   (sign_b),
    .shadow_i (shadow_state),
    .state_o  (live_state),
    .result_o (test_bit)
  );

  fpu_ctlstat_shadow u_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .save_i   (strb.save),
    .live_i   (live_state),
    .shadow_o (shadow_state)
  );

  assign status_word = pack_status(live_state);

  // R2
  set_rm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_SET_RM) |=> (status_word[RM_LSB+RM_W-1:RM_LSB] == $past(cmd_rm)));

  // R7
  save_keeps_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_SAVE) |=> $stable(status_word));

endmodule

// File: tb/fpu_ctlstat_tb_top.sv
module fpu_ctlstat_tb_top;

  typedef struct packed {
    logic        v;
    logic [3:0]  op;
    logic [1:0]  arg;
    logic        gt;
    logic        eq;
    logic        sa;
    logic        sb;
    logic [31:0] w;
    logic        r;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 32;

  // Word = sign<<31 | len<<19 | rm<<7 | bool<<4 | err<<3
  localparam vec_t TBL [NV] = '{
    '{1'b1, 4'd1,  2'd0, 1'b0,1'b0,1'b0,1'b0, 32'h0000_0000, 1'b0, 4'd2},  // R2 toward zero
    '{1'b1, 4'd1,  2'd2, 1'b0,1'b0,1'b0,1'b0, 32'h0000_0100, 1'b0, 4'd2},  // R2 plus
    '{1'b1, 4'd1,  2'd3, 1'b0,1'b0,1'b0,1'b0, 32'h0000_0180, 1'b0, 4'd2},  // R2 minus
    '{1'b1, 4'd1,  2'd1, 1'b0,1'b0,1'b0,1'b0, 32'h0000_0080, 1'b0, 4'd2},  // R2 nearest
    '{1'b1, 4'd2,  2'd0, 1'b0,1'b0,1'b0,1'b0, 32'h0000_0088, 1'b0, 4'd3},  // R3 set err
    '{1'b1, 4'd3,  2'd0, 1'b0,1'b0,1'b0,1'b0, 32'h0000_0080, 1'b0, 4'd3},  // R3 first test
    '{1'b1, 4'd3,  2'd0, 1'b0,1'b0,1'b0,1'b0, 32'h0000_0080, 1'b1, 4'd3},  // R3 second test
    '{1'b1, 4'd5,  2'd0, 1'b0,1'b1,1'b0,1'b0, 32'h0000_0090, 1'b1, 4'd4},  // R4 eq
    '{1'b1, 4'd4,  2'd0, 1'b0,1'b1,1'b0,1'b0, 32'h0000_0080, 1'b0, 4'd4},  // R4 gt of equal
    '{1'b1, 4'd4,  2'd0, 1'b1,1'b0,1'b0,1'b0, 32'h0000_0090, 1'b1, 4'd4},  // R4 gt true
    '{1'b1, 4'd6,  2'd0, 1'b0,1'b0,1'b0,1'b0, 32'h8000_0090, 1'b1, 4'd5},  // R5 set sign
    '{1'b1, 4'd7,  2'd0, 1'b0,1'b0,1'b0,1'b0, 32'h0000_0090, 1'b1, 4'd5},  // R5 abs
    '{1'b1, 4'd8,  2'd0, 1'b0,1'b0,1'b1,1'b0, 32'h8000_0090, 1'b1, 4'd5},  // R5 mul -*+
    '{1'b1, 4'd8,  2'd0, 1'b0,1'b0,1'b1,1'b1, 32'h0000_0090, 1'b1, 4'd5},  // R5 mul -*-
    '{1'b1, 4'd8,  2'd0, 1'b0,1'b0,1'b0,1'b1, 32'h8000_0090, 1'b1, 4'd5},  // R5 mul +*-
    '{1'b1, 4'd9,  2'd0, 1'b0,1'b0,1'b0,1'b0, 32'h8008_0090, 1'b1, 4'd6},  // R6 to single
    '{1'b1, 4'd10, 2'd0, 1'b0,1'b0,1'b0,1'b0, 32'h8000_0090, 1'b1, 4'd6},  // R6 to double
    '{1'b1, 4'd9,  2'd0, 1'b0,1'b0,1'b0,1'b0, 32'h8008_0090, 1'b1, 4'd6},  // R6 to single
    '{1'b0, 4'd2,  2'd0, 1'b0,1'b0,1'b0,1'b0, 32'h8008_0090, 1'b1, 4'd10}, // R10 valid low
    '{1'b1, 4'd15, 2'd0, 1'b0,1'b0,1'b0,1'b0, 32'h8008_0090, 1'b1, 4'd10}, // R10 op 15
    '{1'b1, 4'd0,  2'd0, 1'b0,1'b0,1'b0,1'b0, 32'h8008_0090, 1'b1, 4'd10}, // R10 op 0
    '{1'b1, 4'd2,  2'd0, 1'b0,1'b0,1'b0,1'b0, 32'h8008_0098, 1'b1, 4'd11}, // R11 set err keeps bit
    '{1'b1, 4'd1,  2'd0, 1'b0,1'b0,1'b0,1'b0, 32'h8008_0018, 1'b1, 4'd2},  // R2
    '{1'b1, 4'd11, 2'd0, 1'b0,1'b0,1'b0,1'b0, 32'h8008_0018, 1'b1, 4'd7},  // R7 save
    '{1'b1, 4'd7,  2'd0, 1'b0,1'b0,1'b0,1'b0, 32'h0008_0018, 1'b1, 4'd5},  // R5
    '{1'b1, 4'd10, 2'd0, 1'b0,1'b0,1'b0,1'b0, 32'h0000_0018, 1'b1, 4'd6},  // R6
    '{1'b1, 4'd3,  2'd0, 1'b0,1'b0,1'b0,1'b0, 32'h0000_0010, 1'b0, 4'd3},  // R3
    '{1'b1, 4'd5,  2'd0, 1'b0,1'b0,1'b0,1'b0, 32'h0000_0000, 1'b0, 4'd4},  // R4 eq false
    '{1'b1, 4'd1,  2'd3, 1'b0,1'b0,1'b0,1'b0, 32'h0000_0180, 1'b0, 4'd2},  // R2
    '{1'b1, 4'd12, 2'd0, 1'b0,1'b0,1'b0,1'b0, 32'h8008_0018, 1'b0, 4'd7},  // R7 restore
    '{1'b1, 4'd13, 2'd0, 1'b0,1'b0,1'b0,1'b0, 32'h8008_0090, 1'b0, 4'd8},  // R8 init
    '{1'b1, 4'd3,  2'd0, 1'b0,1'b0,1'b0,1'b0, 32'h8008_0090, 1'b1, 4'd3}   // R3 after init
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd_op = '0;
  logic [1:0]  cmd_rm = '0;
  logic        cmp_gt = 1'b0, cmp_eq = 1'b0, sign_a = 1'b0, sign_b = 1'b0;
  logic [31:0] status_word;
  logic        test_bit;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  fpu_ctlstat dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_rm(cmd_rm), .cmp_gt(cmp_gt), .cmp_eq(cmp_eq), .sign_a(sign_a),
    .sign_b(sign_b), .status_word(status_word), .test_bit(test_bit)
  );

  task automatic check(string req, logic [31:0] w_exp, logic r_exp);
    total++;
    if (status_word !== w_exp || test_bit !== r_exp) begin
      bad++;
      $display("FAIL %s word=%h bit=%b expected word=%h bit=%b",
               req, status_word, test_bit, w_exp, r_exp);
    end
  endtask

  task automatic issue(logic v, logic [3:0] op, logic [1:0] arg,
                       logic gt, logic eq, logic sa, logic sb);
    cmd_valid = v; cmd_op = op; cmd_rm = arg;
    cmp_gt = gt; cmp_eq = eq; sign_a = sa; sign_b = sb;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    check("R1", 32'h0000_0080, 1'b0);

    for (int i = 0; i < NV; i++) begin
      issue(TBL[i].v, TBL[i].op, TBL[i].arg, TBL[i].gt, TBL[i].eq,
            TBL[i].sa, TBL[i].sb);
      check($sformatf("R%0d step %0d", TBL[i].req, i), TBL[i].w, TBL[i].r);
    end

    // R1 reset returns everything to the idle state
    do_reset();
    check("R1", 32'h0000_0080, 1'b0);

    // R9 restore with no prior save, after corrupting the live state
    issue(1'b1, 4'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    issue(1'b1, 4'd6, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    issue(1'b1, 4'd9, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    issue(1'b1, 4'd1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R9", 32'h8008_0108, 1'b0);
    issue(1'b1, 4'd12, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R9", 32'h0000_0080, 1'b0);

    // R11 test bit ignores a test-error with valid low
    issue(1'b1, 4'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    issue(1'b0, 4'd3, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R11", 32'h0000_0088, 1'b0);
    issue(1'b1, 4'd3, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    issue(1'b1, 4'd5, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R11", 32'h0000_0090, 1'b1);
    issue(1'b1, 4'd14, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    issue(1'b1, 4'd7, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R10", 32'h0000_0090, 1'b1);

    // R8 init leaves sign, length and boolean alone
    issue(1'b1, 4'd6, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    issue(1'b1, 4'd9, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    issue(1'b1, 4'd1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    issue(1'b1, 4'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    issue(1'b1, 4'd13, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R8", 32'h8008_0090, 1'b1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule